// File: doc/BRIEF.md
# Tagged Multi-Line Receive Silo

This block gathers characters finished by eight serial line receivers into one shared first-in first-out store. A receiver reports a finished character by pulsing its ready strobe for one clock, with the character and its parity and framing error flags alongside. Each stored entry records the character, the number of the line it came from and its error flags. When several lines finish in the same cycle, they are taken into the store one per clock in rotating order.

A host reads a single 16-bit word that always shows the oldest entry. The word's top bit is set while an entry is present, so the word is negative as a signed value exactly when data is waiting. Pulsing the read strobe removes that entry. A 16-bit control word turns on line scanning and the receive interrupt, and chooses how the interrupt is raised: either once any character is waiting, or only after the fill reaches an alarm level. In the alarm mode the host can collect characters in batches.

Top module: `rx_silo`

## Requirements
- R1: The read word shows the oldest entry with bit 15 set, the character in bits 7:0, the line number in bits 10:8 and bit 11 at zero. A character strobed at one clock edge becomes readable after the second edge that follows.
- R2: A parity error on the incoming character sets bit 12 of its entry. A framing error, which is also how a break on the line is reported, sets bit 13. The character bits are kept as received.
- R3: The store holds up to 64 entries and returns them in the order they were written. Its fill never goes above 64.
- R4: A character strobed while the store holds 64 entries is dropped. The next entry written for that line carries bit 14 (overrun), and later entries for that line do not.
- R5: Characters that finish in the same cycle are written one per clock. The search starts at the line after the one most recently written and wraps from line 7 to line 0. After reset it starts at line 0.
- R6: When the store is empty the read word is all zero. A read strobe at that time leaves the store unchanged.
- R7: While control bit 5 (scan enable) is clear, the store, the waiting characters and the overrun marks are all cleared, and strobes are ignored.
- R8: With control bit 6 (receive interrupt enable) set and control bit 12 (alarm enable) clear, the interrupt is high whenever an entry is present.
- R9: With control bit 12 set, the interrupt is high only while the store holds 16 or more entries.
- R10: The interrupt stays low while control bit 6 or control bit 5 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctrl_word | input | 16 | Control: bit 5 scan enable, bit 6 receive interrupt enable, bit 12 alarm enable |
| line_rdy | input | 8 | One-clock character-finished strobe per line |
| line_data | input | 64 | Character of line i in bits 8i+7:8i |
| line_perr | input | 8 | Parity error flag per line, valid with its strobe |
| line_ferr | input | 8 | Framing error or break flag per line, valid with its strobe |
| rd_en | input | 1 | Read strobe; removes the oldest entry |
| rd_data | output | 16 | Receive word for the oldest entry |
| irq | output | 1 | Receive interrupt |

## Verification
The assertions check on every cycle that an empty word reads as zero with bit 11 clear, that the fill stays within 64, that at most one line is written per clock, that the store is empty after a cycle with scan disabled, and that the interrupt agrees with the enable bits, the fill level and the alarm threshold. Only the bench scenarios can show that entries come out in order with the right line number and error tags, that the rotating order follows the last line written, and that a character dropped while the store is full marks exactly the next entry of its line with overrun.

// File: rtl/rx_silo_pkg.sv
// Package: shared constants and the stored entry type for the receive silo.
// Assumes at most eight lines, because the line field of the word is 3 bits.
package rx_silo_pkg;

    localparam int CHAR_W        = 8;
    localparam int LINE_FIELD_W  = 3;
    localparam int CTL_SCAN_BIT  = 5;
    localparam int CTL_RXIE_BIT  = 6;
    localparam int CTL_ALARM_BIT = 12;

    typedef struct packed {
        logic                    ovr;
        logic                    ferr;
        logic                    perr;
        logic [LINE_FIELD_W-1:0] line;
        logic [CHAR_W-1:0]       data;
    } silo_entry_t;

    localparam int ENTRY_W = $bits(silo_entry_t);

endpackage

// File: rtl/rx_line_slot.sv
// Module: holding slot for one line. It takes a finished character and keeps
// it until the arbiter grants it. It also keeps the line's overrun mark.
// Assumes a grant comes only while the slot is valid and the store has room.
module rx_line_slot
    import rx_silo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_en,
    input  logic              strobe,
    input  logic [CHAR_W-1:0] char_in,
    input  logic              perr_in,
    input  logic              ferr_in,
    input  logic              store_full,
    input  logic              grant,
    output logic              pend_vld,
    output logic [CHAR_W-1:0] pend_char,
    output logic              pend_perr,
    output logic              pend_ferr,
    output logic              pend_ovr
);

    logic lose;

    // Drop the character when the store is full or the slot is still occupied
    assign lose = strobe && (store_full || (pend_vld && !grant));

    // Slot contents: cleared by reset or scan off, freed by grant, loaded by a strobe
    always_ff @(posedge clk) begin
        if (!rst_n || !scan_en) begin
            pend_vld  <= 1'b0;
            pend_char <= '0;
            pend_perr <= 1'b0;
            pend_ferr <= 1'b0;
        end else begin
            if (grant)
                pend_vld <= 1'b0;
            if (strobe && !lose) begin
                pend_vld  <= 1'b1;
                pend_char <= char_in;
                pend_perr <= perr_in;
                pend_ferr <= ferr_in;
            end
        end
    end

    // Overrun mark: set by a loss, cleared once an entry carrying it is written
    always_ff @(posedge clk) begin
        if (!rst_n || !scan_en)
            pend_ovr <= 1'b0;
        else if (lose)
            pend_ovr <= 1'b1;
        else if (grant)
            pend_ovr <= 1'b0;
    end

endmodule

// File: rtl/rx_rr_arb.sv
// Module: rotating arbiter. It grants at most one requesting line per clock.
// The search starts at the line after the last line granted.
// Assumes NUM_LINES is at least 2.
module rx_rr_arb #(
    parameter int NUM_LINES = 8,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic [NUM_LINES-1:0] req,
    output logic [NUM_LINES-1:0] grant,
    output logic [IDX_W-1:0]     grant_idx,
    output logic                 grant_vld
);

    logic [IDX_W-1:0] start_q;

    // Pick the first requester at or after the start index, going round
    always_comb begin
        grant     = '0;
        grant_idx = '0;
        grant_vld = 1'b0;
        for (int k = 0; k < NUM_LINES; k++) begin
            int j;
            j = (int'(start_q) + k) % NUM_LINES;
            if (enable && !grant_vld && req[j]) begin
                grant_vld = 1'b1;
                grant[j]  = 1'b1;
                grant_idx = IDX_W'(j);
            end
        end
    end

    // Move the start to the line after the one just granted
    always_ff @(posedge clk) begin
        if (!rst_n)
            start_q <= '0;
        else if (grant_vld)
            start_q <= (grant_idx == IDX_W'(NUM_LINES - 1)) ? '0 : grant_idx + 1'b1;
    end

endmodule

// File: rtl/rx_silo_fifo.sv
// Module: circular store of entries with a fill counter and a synchronous clear.
// Assumes push is never asserted while full and pop is never asserted while empty.
module rx_silo_fifo #(
    parameter int DEPTH   = 64,
    parameter int WIDTH   = 14,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    // Step a pointer forward, wrapping at the depth
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write on push
    always_ff @(posedge clk) begin
        if (push)
            mem[wr_ptr] <= push_data;
    end

    // Pointers and fill count
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)
                wr_ptr <= bump(wr_ptr);
            if (pop)
                rd_ptr <= bump(rd_ptr);
            if (push && !pop)
                count <= count + 1'b1;
            else if (pop && !push)
                count <= count - 1'b1;
        end
    end

    assign head  = mem[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));

endmodule

// File: rtl/rx_silo.sv
// Module: top of the receive silo. Per-line slots feed a rotating arbiter,
// which writes one tagged entry per clock into the shared store. The oldest
// entry is shown as a 16-bit word, and the interrupt follows the control enables.
// Assumes NUM_LINES <= 8 and line strobes are single-clock pulses.
module rx_silo
    import rx_silo_pkg::*;
#(
    parameter int NUM_LINES   = 8,
    parameter int DEPTH       = 64,
    parameter int ALARM_LEVEL = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [15:0]                 ctrl_word,
    input  logic [NUM_LINES-1:0]        line_rdy,
    input  logic [NUM_LINES*CHAR_W-1:0] line_data,
    input  logic [NUM_LINES-1:0]        line_perr,
    input  logic [NUM_LINES-1:0]        line_ferr,
    input  logic                        rd_en,
    output logic [15:0]                 rd_data,
    output logic                        irq
);

    localparam int IDX_W = $clog2(NUM_LINES);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic scan_en, rx_ie, alarm_en;
    logic [NUM_LINES-1:0] pend_vld, pend_perr, pend_ferr, pend_ovr, arb_grant;
    logic [CHAR_W-1:0]    pend_char [NUM_LINES];
    logic [IDX_W-1:0]     grant_idx;
    logic                 grant_vld, fifo_push, fifo_pop, fifo_empty, fifo_full;
    logic [CNT_W-1:0]     fill_cnt;
    silo_entry_t          new_entry, head_entry;

    assign scan_en  = ctrl_word[CTL_SCAN_BIT];
    assign rx_ie    = ctrl_word[CTL_RXIE_BIT];
    assign alarm_en = ctrl_word[CTL_ALARM_BIT];

    // One holding slot per line
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_slot
        rx_line_slot u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .scan_en    (scan_en),
            .strobe     (line_rdy[i]),
            .char_in    (line_data[i*CHAR_W +: CHAR_W]),
            .perr_in    (line_perr[i]),
            .ferr_in    (line_ferr[i]),
            .store_full (fifo_full),
            .grant      (arb_grant[i]),
            .pend_vld   (pend_vld[i]),
            .pend_char  (pend_char[i]),
            .pend_perr  (pend_perr[i]),
            .pend_ferr  (pend_ferr[i]),
            .pend_ovr   (pend_ovr[i])
        );
    end

    rx_rr_arb #(.NUM_LINES(NUM_LINES)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (scan_en && !fifo_full),
        .req       (pend_vld),
        .grant     (arb_grant),
        .grant_idx (grant_idx),
        .grant_vld (grant_vld)
    );

    // Build the tagged entry of the granted line
    always_comb begin
        new_entry.data = pend_char[grant_idx];
        new_entry.line = LINE_FIELD_W'(grant_idx);
        new_entry.perr = pend_perr[grant_idx];
        new_entry.ferr = pend_ferr[grant_idx];
        new_entry.ovr  = pend_ovr[grant_idx];
    end

    assign fifo_push = grant_vld;
    assign fifo_pop  = rd_en && !fifo_empty && scan_en;

    rx_silo_fifo #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (!scan_en),
        .push      (fifo_push),
        .push_data (new_entry),
        .pop       (fifo_pop),
        .head      (head_entry),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .count     (fill_cnt)
    );

    // Receive word: zero when empty, otherwise the valid bit and the tagged head
    always_comb begin
        if (fifo_empty)
            rd_data = '0;
        else
            rd_data = {1'b1, head_entry.ovr, head_entry.ferr, head_entry.perr,
                       1'b0, head_entry.line, head_entry.data};
    end

    // Interrupt: per character, or at the alarm level when alarm mode is on
    assign irq = scan_en && rx_ie &&
                 (alarm_en ? (fill_cnt >= CNT_W'(ALARM_LEVEL)) : !fifo_empty);

endmodule

// File: rtl/rx_silo_checker.sv
// Module: assertion checker for rx_silo, attached to it by bind.
// Assumes it sees the top's ports plus the fill count, push and grant vector.
module rx_silo_checker #(
    parameter int NUM_LINES   = 8,
    parameter int DEPTH       = 64,
    parameter int ALARM_LEVEL = 16,
    localparam int CNT_W      = $clog2(DEPTH + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [15:0]          ctrl_word,
    input logic                 rd_en,
    input logic [15:0]          rd_data,
    input logic                 irq,
    input logic [CNT_W-1:0]     fill_cnt,
    input logic                 push,
    input logic [NUM_LINES-1:0] grant
);

    logic scan, ie, alarm;
    assign scan  = ctrl_word[5];
    assign ie    = ctrl_word[6];
    assign alarm = ctrl_word[12];

    p_spare_bit_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[11] == 1'b0);

    p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt <= CNT_W'(DEPTH));

    p_one_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    p_empty_word_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[15] |-> (rd_data == 16'h0000));

    p_empty_read_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (scan && fill_cnt == '0 && rd_en && !push) |=> (fill_cnt == '0));

    p_scan_off_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !scan |=> (fill_cnt == '0 && !rd_data[15]));

    p_char_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (scan && ie && !alarm && rd_data[15]) |-> irq);

    p_alarm_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (scan && ie && alarm) |-> (irq == (fill_cnt >= CNT_W'(ALARM_LEVEL))));

    p_irq_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (scan && ie));

endmodule

bind rx_silo rx_silo_checker #(
    .NUM_LINES   (NUM_LINES),
    .DEPTH       (DEPTH),
    .ALARM_LEVEL (ALARM_LEVEL)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_word (ctrl_word),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .irq       (irq),
    .fill_cnt  (fill_cnt),
    .push      (fifo_push),
    .grant     (arb_grant)
);

// File: tb/rx_silo_tb_top.sv
// Scoreboard bench: the send tasks push expected words into a queue, and the
// read task pops and compares them against the receive word.
module rx_silo_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ctrl_word = '0;
    logic [7:0]  line_rdy = '0;
    logic [63:0] line_data = '0;
    logic [7:0]  line_perr = '0;
    logic [7:0]  line_ferr = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_q [$];
    bit   ovr_m [8];
    int   rr_next = 0;

    localparam logic [15:0] SCAN  = 16'h0020;
    localparam logic [15:0] RXIE  = 16'h0040;
    localparam logic [15:0] ALARM = 16'h1000;

    always #5 clk = ~clk;

    rx_silo dut_i (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .line_rdy(line_rdy),
        .line_data(line_data), .line_perr(line_perr), .line_ferr(line_ferr),
        .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Driver: one strobe on one line, then an expected word or an overrun mark
    task automatic send(input int ln, input logic [7:0] d, input bit pe, input bit fe,
                        input bit lost);
        line_data[ln*8 +: 8] = d;
        line_perr[ln] = pe;
        line_ferr[ln] = fe;
        line_rdy[ln]  = 1'b1;
        step();
        line_rdy = '0;
        line_perr = '0;
        line_ferr = '0;
        step();
        if (lost) begin
            ovr_m[ln] = 1'b1;
        end else begin
            exp_q.push_back({1'b1, ovr_m[ln], fe, pe, 1'b0, 3'(ln), d});
            ovr_m[ln] = 1'b0;
            rr_next = (ln + 1) % 8;
        end
    endtask

    // Driver: simultaneous strobes, with the expected rotating order
    task automatic send_multi(input logic [7:0] mask, input logic [7:0] base);
        int start;
        int last;
        start = rr_next;
        last = rr_next;
        for (int i = 0; i < 8; i++) line_data[i*8 +: 8] = base + 8'(i);
        line_rdy = mask;
        step();
        line_rdy = '0;
        for (int k = 0; k < 8; k++) begin
            int j;
            j = (start + k) % 8;
            if (mask[j]) begin
                exp_q.push_back({1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'(j), base + 8'(j)});
                last = j;
            end
        end
        rr_next = (last + 1) % 8;
        repeat (9) step();
    endtask

    // Monitor: compare the head word to the queue front, then pop it
    task automatic read_check(input string req);
        logic [15:0] e;
        e = exp_q.pop_front();
        check(rd_data === e, req, int'(rd_data), int'(e));
        rd_en = 1'b1;
        step();
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) step();
        rst_n = 1'b1;
        step();
        check(rd_data === 16'h0000, "R6 reset word", int'(rd_data), 0);
        check(irq === 1'b0, "R10 reset irq", int'(irq), 0);

        ctrl_word = SCAN | RXIE;
        step();
        // R6: read while empty, then one entry must come out intact
        rd_en = 1'b1; step(); rd_en = 1'b0;
        check(rd_data === 16'h0000, "R6 empty read", int'(rd_data), 0);
        send(2, 8'h41, 0, 0, 0);
        check(irq === 1'b1, "R8 irq on char", int'(irq), 1);
        read_check("R1 first entry");
        check(rd_data === 16'h0000, "R6 empty after pop", int'(rd_data), 0);
        check(irq === 1'b0, "R8 irq drops", int'(irq), 0);

        // R2: error tags
        send(6, 8'h33, 1, 0, 0);
        send(1, 8'h00, 0, 1, 0);
        read_check("R2 parity tag");
        read_check("R2 framing tag");

        // R5: rotating order with simultaneous strobes
        send_multi(8'hFF, 8'h80);
        for (int i = 0; i < 8; i++) read_check("R5 all lines");
        send_multi(8'hA5, 8'hC0);
        for (int i = 0; i < 4; i++) read_check("R5 partial mask");

        // R10: interrupt enable off
        ctrl_word = SCAN;
        send(4, 8'h5A, 0, 0, 0);
        check(irq === 1'b0, "R10 irq masked", int'(irq), 0);
        ctrl_word = SCAN | RXIE;
        #1;
        check(irq === 1'b1, "R10 irq unmasked", int'(irq), 1);
        read_check("R1 masked entry");

        // R9, R3, R4: alarm level, full store and a dropped character
        ctrl_word = SCAN | RXIE | ALARM;
        for (int n = 1; n <= 64; n++) begin
            send(n % 8, 8'(n), 0, 0, 0);
            if (n == 1)  check(irq === 1'b0, "R9 below alarm one", int'(irq), 0);
            if (n == 15) check(irq === 1'b0, "R9 below alarm", int'(irq), 0);
            if (n == 16) check(irq === 1'b1, "R9 at alarm", int'(irq), 1);
        end
        send(3, 8'hAA, 0, 0, 1);
        for (int n = 64; n >= 1; n--) begin
            read_check("R3 ordered drain");
            if (n == 16) check(irq === 1'b0, "R9 under alarm after reads", int'(irq), 0);
        end
        check(rd_data === 16'h0000, "R4 dropped char absent", int'(rd_data), 0);
        send(3, 8'h55, 0, 0, 0);
        send(3, 8'h56, 0, 0, 0);
        ctrl_word = SCAN | RXIE;
        read_check("R4 overrun tagged");
        read_check("R4 overrun cleared");

        // R7: scan disable clears and ignores strobes
        send(0, 8'h11, 0, 0, 0);
        send(5, 8'h12, 0, 0, 0);
        ctrl_word = RXIE;
        step();
        check(rd_data === 16'h0000, "R7 cleared", int'(rd_data), 0);
        check(irq === 1'b0, "R7 irq off", int'(irq), 0);
        line_data[7:0] = 8'h77;
        line_rdy[0] = 1'b1; step(); line_rdy = '0; step();
        ctrl_word = SCAN | RXIE;
        repeat (3) step();
        check(rd_data === 16'h0000, "R7 strobe ignored", int'(rd_data), 0);
        exp_q.delete();
        send(7, 8'h3C, 0, 0, 0);
        read_check("R7 resumes");

        finish_run();
    end

endmodule